// File: doc/BRIEF.md
# Duty-Cycled Sniff Sequencer

This block keeps a radio receiver asleep for most of the time. It wakes the receiver at regular intervals to check for a carrier. It runs from a slow always-on clock, nominally 10 kHz. During each sleep interval the receiver and the crystal oscillator are disabled. The interval is a programmable number of steps, and each step is either a fine unit (0.5 ms) or a coarse unit (64 ms), chosen by one resolution bit. With 8-bit step counts this gives poll periods from 0.5 ms up to about 16 s. The step lengths, in slow-clock cycles, are parameters.

Once the interval expires, the block powers the receiver and oscillator up and waits a programmable settling time. It then waits a further programmable delay and strobes the signal-strength comparison for one cycle. If the signal is above threshold and wake-on-signal is enabled, the block raises a wake indication for a programmable time and then stays in full receive until the host commands an exit. In every other case it goes straight back to sleep.

All timing and enable settings are captured in the first cycle of every sleep visit. A host may therefore rewrite them at any time without disturbing a poll cycle that is already under way.

Top module: `sniff_sequencer`

## Requirements
- R1: While `rst_n` is low, all five outputs are low. The block leaves reset into the first cycle of a sleep visit.
- R2: A sleep visit lasts 1 capture cycle plus (`off_steps`+1) × step cycles. Throughout the visit `rx_on`, `xtal_on`, `rssi_strobe`, `wake_irq` and `rx_mode` are all low.
- R3: The step length is FINE_TICKS cycles when `coarse_res`=0 and COARSE_TICKS cycles when `coarse_res`=1.
- R4: After sleep, a power-up phase lasts `pwrup_ticks`+1 cycles. During it `rx_on` and `xtal_on` are high and `rx_mode` and `rssi_strobe` are low.
- R5: After power-up, a wait phase lasts `chk_delay`+1 cycles with the receiver on. It is followed by exactly one cycle with `rssi_strobe` high.
- R6: If `rssi_above` and the captured wake-on-signal enable are both 1 in the strobe cycle, `wake_irq` is high for the next `irq_len`+1 cycles, with `rx_mode` high.
- R7: If either `rssi_above` or the captured wake-on-signal enable is 0 in the strobe cycle, the next cycle starts a new sleep visit with all outputs low.
- R8: After the wake indication, `rx_mode` stays high until a cycle in which `rx_exit` is 1. The next cycle then starts a sleep visit. `rx_exit` has no effect during sleep, power-up, wait, strobe or wake-indication cycles.
- R9: `off_steps`, `coarse_res`, `pwrup_ticks`, `chk_delay`, `irq_len` and `wake_on_rssi` are sampled only in the first cycle of a sleep visit. Changes at any other time take effect only at the next sleep visit.
- R10: `xtal_on` equals `rx_on` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rssi_above | input | 1 | Signal strength above sniff threshold |
| wake_on_rssi | input | 1 | Enable hand-over to receive on a detected carrier |
| coarse_res | input | 1 | Sleep step unit: 0 fine, 1 coarse |
| off_steps | input | REG_W | Sleep length in steps, minus one |
| pwrup_ticks | input | REG_W | Receiver settling time in cycles, minus one |
| chk_delay | input | REG_W | Extra wait before the strobe in cycles, minus one |
| irq_len | input | REG_W | Wake indication length in cycles, minus one |
| rx_exit | input | 1 | Host command to leave full receive |
| rx_on | output | 1 | Receiver power enable |
| xtal_on | output | 1 | Crystal oscillator enable |
| rssi_strobe | output | 1 | One-cycle sample strobe for the comparison |
| wake_irq | output | 1 | Wake indication to the host |
| rx_mode | output | 1 | Full receive mode flag |

## Verification
Two pairs of events can coincide in one cycle. The first is a host register write landing in the capture cycle of a sleep visit. The second is `rx_exit` arriving in the last wake-indication cycle, exactly as the block moves into receive. A random phase rewrites every setting on every cycle and pulses `rx_exit` at random, and directed runs hold `rx_exit` high across whole poll cycles, so both collisions occur many times. Each is judged by a cycle-level reference model in the bench. The model applies the values present in the capture cycle and ignores `rx_exit` until the first receive cycle.

// File: rtl/sniff_seq_pkg.sv
// Shared state encoding for the sniff sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sniff_seq_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP     = 3'd0,
        ST_POWERUP   = 3'd1,
        ST_RSSI_WAIT = 3'd2,
        ST_CHECK     = 3'd3,
        ST_IRQ       = 3'd4,
        ST_RECEIVE   = 3'd5
    } sniff_state_e;

    // True for every state in which the receiver front end is powered.
    function automatic logic state_powered(sniff_state_e s);
        return (s != ST_SLEEP);
    endfunction

    // True for the states that belong to full receive.
    function automatic logic state_receiving(sniff_state_e s);
        return (s == ST_IRQ) || (s == ST_RECEIVE);
    endfunction

endpackage

// File: rtl/sniff_cfg_shadow.sv
// Holds the settings used by one poll cycle.
// The settings are captured when 'capture' is high, which is the first cycle
// of a sleep visit, and held until the next capture.
// Assumes: capture is a single-cycle pulse from the sequencer.
module sniff_cfg_shadow #(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             wake_in,
    input  logic [REG_W-1:0] pwrup_in,
    input  logic [REG_W-1:0] chk_in,
    input  logic [REG_W-1:0] irq_in,
    output logic             wake_q,
    output logic [REG_W-1:0] pwrup_q,
    output logic [REG_W-1:0] chk_q,
    output logic [REG_W-1:0] irq_q
);

    // Capture the settings at the start of each sleep visit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q  <= 1'b0;
            pwrup_q <= '0;
            chk_q   <= '0;
            irq_q   <= '0;
        end else if (capture) begin
            wake_q  <= wake_in;
            pwrup_q <= pwrup_in;
            chk_q   <= chk_in;
            irq_q   <= irq_in;
        end
    end

endmodule

// File: rtl/sniff_sleep_timer.sv
// Measures the sleep interval as a number of steps times a step length.
// A step is FINE_TICKS or COARSE_TICKS clock cycles.
// 'load' starts an interval of (steps_in+1) steps. 'done' is high in the
// last running cycle of the interval.
// Assumes: FINE_TICKS and COARSE_TICKS are at least 1, and COARSE_TICKS is
// not smaller than FINE_TICKS.
module sniff_sleep_timer #(
    parameter int unsigned REG_W        = 8,
    parameter int unsigned FINE_TICKS   = 5,
    parameter int unsigned COARSE_TICKS = 640
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic             coarse_in,
    input  logic [REG_W-1:0] steps_in,
    output logic             done
);

    localparam int unsigned PRE_W = $clog2(COARSE_TICKS + 1);
    localparam logic [PRE_W-1:0] FINE_LAST   = PRE_W'(FINE_TICKS - 1);
    localparam logic [PRE_W-1:0] COARSE_LAST = PRE_W'(COARSE_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [REG_W-1:0] steps_q;
    logic             coarse_q;
    logic [PRE_W-1:0] reload_val;

    // Pick the step reload value from the resolution in use.
    always_comb begin
        reload_val = coarse_q ? COARSE_LAST : FINE_LAST;
    end

    // Count cycles within a step, then steps within the interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            steps_q  <= '0;
            coarse_q <= 1'b0;
        end else if (load) begin
            coarse_q <= coarse_in;
            steps_q  <= steps_in;
            pre_q    <= coarse_in ? COARSE_LAST : FINE_LAST;
        end else if (run) begin
            if (pre_q != '0) begin
                pre_q <= pre_q - 1'b1;
            end else if (steps_q != '0) begin
                steps_q <= steps_q - 1'b1;
                pre_q   <= reload_val;
            end
        end
    end

    // Flag the final cycle of the interval.
    always_comb begin
        done = run && (pre_q == '0) && (steps_q == '0);
    end

endmodule

// File: rtl/sniff_phase_counter.sv
// Down counter shared by the power-up, wait and wake-indication phases.
// A phase loaded with value N lasts N+1 cycles; 'zero' marks its last cycle.
// Assumes: load takes priority over run.
module sniff_phase_counter #(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);

    logic [REG_W-1:0] cnt_q;

    // Load at phase entry, count down while the phase runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Mark the final cycle of the current phase.
    always_comb begin
        zero = (cnt_q == '0);
    end

endmodule

// File: rtl/sniff_sequencer.sv
// Duty-cycled sniff sequencer.
// The block sleeps, powers the receiver, waits, strobes the signal-strength
// comparison, and then either sleeps again or raises a wake indication and
// holds full receive until the host asks it to leave.
// Assumes: clk is the slow always-on clock, and all inputs are synchronous
// to it.
module sniff_sequencer
    import sniff_seq_pkg::*;
#(
    parameter int unsigned REG_W        = 8,
    parameter int unsigned FINE_TICKS   = 5,
    parameter int unsigned COARSE_TICKS = 640
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rssi_above,
    input  logic             wake_on_rssi,
    input  logic             coarse_res,
    input  logic [REG_W-1:0] off_steps,
    input  logic [REG_W-1:0] pwrup_ticks,
    input  logic [REG_W-1:0] chk_delay,
    input  logic [REG_W-1:0] irq_len,
    input  logic             rx_exit,
    output logic             rx_on,
    output logic             xtal_on,
    output logic             rssi_strobe,
    output logic             wake_irq,
    output logic             rx_mode
);

    sniff_state_e     state_q, state_d;
    logic             entry_q;
    logic             capture;
    logic             sleep_run;
    logic             sleep_done;
    logic             ph_load;
    logic [REG_W-1:0] ph_val;
    logic             ph_run;
    logic             ph_zero;
    logic             sh_wake;
    logic [REG_W-1:0] sh_pwrup;
    logic [REG_W-1:0] sh_chk;
    logic [REG_W-1:0] sh_irq;

    // Derive the capture pulse and the sleep-run enable from the state.
    always_comb begin
        capture   = (state_q == ST_SLEEP) && entry_q;
        sleep_run = (state_q == ST_SLEEP) && !entry_q;
        ph_run    = (state_q == ST_POWERUP) || (state_q == ST_RSSI_WAIT) ||
                    (state_q == ST_IRQ);
    end

    sniff_cfg_shadow #(
        .REG_W (REG_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .wake_in  (wake_on_rssi),
        .pwrup_in (pwrup_ticks),
        .chk_in   (chk_delay),
        .irq_in   (irq_len),
        .wake_q   (sh_wake),
        .pwrup_q  (sh_pwrup),
        .chk_q    (sh_chk),
        .irq_q    (sh_irq)
    );

    sniff_sleep_timer #(
        .REG_W        (REG_W),
        .FINE_TICKS   (FINE_TICKS),
        .COARSE_TICKS (COARSE_TICKS)
    ) u_sleep (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (capture),
        .run       (sleep_run),
        .coarse_in (coarse_res),
        .steps_in  (off_steps),
        .done      (sleep_done)
    );

    sniff_phase_counter #(
        .REG_W (REG_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .run      (ph_run),
        .zero     (ph_zero)
    );

    // Next-state logic, and the phase counter load on each transition.
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (state_q)
            ST_SLEEP: begin
                if (sleep_done) begin
                    state_d = ST_POWERUP;
                    ph_load = 1'b1;
                    ph_val  = sh_pwrup;
                end
            end
            ST_POWERUP: begin
                if (ph_zero) begin
                    state_d = ST_RSSI_WAIT;
                    ph_load = 1'b1;
                    ph_val  = sh_chk;
                end
            end
            ST_RSSI_WAIT: begin
                if (ph_zero) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (rssi_above && sh_wake) begin
                    state_d = ST_IRQ;
                    ph_load = 1'b1;
                    ph_val  = sh_irq;
                end else begin
                    state_d = ST_SLEEP;
                end
            end
            ST_IRQ: begin
                if (ph_zero) begin
                    state_d = ST_RECEIVE;
                end
            end
            ST_RECEIVE: begin
                if (rx_exit) begin
                    state_d = ST_SLEEP;
                end
            end
            default: state_d = ST_SLEEP;
        endcase
    end

    // State register, plus a flag marking the first cycle of a sleep visit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            entry_q <= 1'b1;
        end else begin
            state_q <= state_d;
            entry_q <= (state_d == ST_SLEEP) && (state_q != ST_SLEEP);
        end
    end

    // Decode the outputs from the current state (Moore outputs).
    always_comb begin
        rx_on       = state_powered(state_q);
        xtal_on     = state_powered(state_q);
        rssi_strobe = (state_q == ST_CHECK);
        wake_irq    = (state_q == ST_IRQ);
        rx_mode     = state_receiving(state_q);
    end

endmodule

// File: rtl/sniff_sequencer_checker.sv
// Timing properties of the sniff sequencer, observed at its ports.
// Assumes: bound to every instance of sniff_sequencer.
module sniff_sequencer_checker (
    input logic clk,
    input logic rst_n,
    input logic rssi_above,
    input logic rx_exit,
    input logic rx_on,
    input logic xtal_on,
    input logic rssi_strobe,
    input logic wake_irq,
    input logic rx_mode
);

    // The oscillator is enabled in exactly the cycles the receiver is.
    assert_xtal_tracks_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_on == rx_on);

    // The sample strobe never lasts more than one cycle.
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rssi_strobe |=> !rssi_strobe);

    // A strobe with the signal below threshold is followed by sleep.
    assert_miss_sleeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rssi_strobe && !rssi_above) |=> (!rx_on && !rx_mode));

    // The wake indication only appears inside receive mode.
    assert_irq_in_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> rx_mode);

    // Receive entry comes straight from a strobe and starts with the indication.
    assert_rx_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_mode) |-> (wake_irq && $past(rssi_strobe)));

    // Receive holds until the host exit command.
    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode && !wake_irq && !rx_exit) |=> rx_mode);

    // Waking always begins with power-up, not with a strobe or receive.
    assert_powerup_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_on) |-> (!rx_mode && !rssi_strobe));

endmodule

bind sniff_sequencer sniff_sequencer_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rssi_above  (rssi_above),
    .rx_exit     (rx_exit),
    .rx_on       (rx_on),
    .xtal_on     (xtal_on),
    .rssi_strobe (rssi_strobe),
    .wake_irq    (wake_irq),
    .rx_mode     (rx_mode)
);

// File: tb/sniff_sequencer_test.sv
// Bench for sniff_sequencer: a behavioural reference model runs beside the
// design and every output is compared on each clock.
module sniff_sequencer_test;

    localparam int FINE   = 2;
    localparam int COARSE = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rssi_above = 1'b0;
    logic       wake_on_rssi = 1'b0;
    logic       coarse_res = 1'b0;
    logic [7:0] off_steps = 8'd0;
    logic [7:0] pwrup_ticks = 8'd0;
    logic [7:0] chk_delay = 8'd0;
    logic [7:0] irq_len = 8'd0;
    logic       rx_exit = 1'b0;
    logic       rx_on, xtal_on, rssi_strobe, wake_irq, rx_mode;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string scen = "R1";

    // Reference model state: phase 0 sleep, 1 power-up, 2 wait, 3 strobe,
    // 4 wake indication, 5 receive.
    int mph = 0;
    int mcnt = 0;
    bit mload = 1'b1;
    int s_pw, s_chk, s_irq;
    bit s_wake;

    always #2.5 clk = ~clk;

    sniff_sequencer #(
        .REG_W        (8),
        .FINE_TICKS   (FINE),
        .COARSE_TICKS (COARSE)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rssi_above   (rssi_above),
        .wake_on_rssi (wake_on_rssi),
        .coarse_res   (coarse_res),
        .off_steps    (off_steps),
        .pwrup_ticks  (pwrup_ticks),
        .chk_delay    (chk_delay),
        .irq_len      (irq_len),
        .rx_exit      (rx_exit),
        .rx_on        (rx_on),
        .xtal_on      (xtal_on),
        .rssi_strobe  (rssi_strobe),
        .wake_irq     (wake_irq),
        .rx_mode      (rx_mode)
    );

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mph   = 0;
            mload = 1'b1;
        end else begin
            case (mph)
                0: begin
                    if (mload) begin
                        s_pw   = int'(pwrup_ticks);
                        s_chk  = int'(chk_delay);
                        s_irq  = int'(irq_len);
                        s_wake = wake_on_rssi;
                        mcnt   = (int'(off_steps) + 1) * (coarse_res ? COARSE : FINE);
                        mload  = 1'b0;
                    end else if (mcnt <= 1) begin
                        mph  = 1;
                        mcnt = s_pw + 1;
                    end else mcnt--;
                end
                1: if (mcnt <= 1) begin mph = 2; mcnt = s_chk + 1; end else mcnt--;
                2: if (mcnt <= 1) mph = 3; else mcnt--;
                3: if (rssi_above && s_wake) begin mph = 4; mcnt = s_irq + 1; end
                   else begin mph = 0; mload = 1'b1; end
                4: if (mcnt <= 1) mph = 5; else mcnt--;
                5: if (rx_exit) begin mph = 0; mload = 1'b1; end
                default: mph = 0;
            endcase
        end
    end

    // Requirement tag for the current model phase.
    function automatic string phase_req();
        if (!rst_n) return "R1";
        case (mph)
            0: return "R2";
            1: return "R4";
            2, 3: return "R5";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string name, string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s/%s %s at cycle %0d: act=%b exp=%b", req, scen, name, cyc, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            chk("rx_on",       phase_req(), rx_on,       rst_n && mph != 0);
            chk("xtal_on",     "R10",       xtal_on,     rst_n && mph != 0);
            chk("rssi_strobe", phase_req(), rssi_strobe, rst_n && mph == 3);
            chk("wake_irq",    phase_req(), wake_irq,    rst_n && mph == 4);
            chk("rx_mode",     phase_req(), rx_mode,     rst_n && mph >= 4);
            if (cyc > 100000) begin
                total++;
                bad++;
                $display("FAIL R1 watchdog expired: act=%0d exp<=100000 cycles", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_cfg(int st, bit crs, int pw, int cd, int il, bit wk);
        off_steps    = 8'(st);
        coarse_res   = crs;
        pwrup_ticks  = 8'(pw);
        chk_delay    = 8'(cd);
        irq_len      = 8'(il);
        wake_on_rssi = wk;
    endtask

    initial begin
        // R1: outputs held low through reset.
        scen = "R1";
        set_cfg(2, 1'b0, 1, 2, 1, 1'b1);
        wait_cyc(4);
        rst_n = 1'b1;

        // R2, R4, R5, R7: signal below threshold, repeated misses.
        scen = "R7";
        rssi_above = 1'b0;
        wait_cyc(60);

        // R7: signal present but wake disabled (takes effect next sleep, R9).
        set_cfg(1, 1'b0, 0, 1, 1, 1'b0);
        rssi_above = 1'b1;
        wait_cyc(60);

        // R6, R8: hit with exit held high, ignored until receive.
        scen = "R8";
        set_cfg(0, 1'b0, 2, 0, 3, 1'b1);
        rx_exit = 1'b1;
        wait_cyc(80);

        // R8: receive holds without the exit command, then leaves on a pulse.
        rx_exit = 1'b0;
        wait_cyc(40);
        rx_exit = 1'b1;
        wait_cyc(1);
        rx_exit = 1'b0;
        rssi_above = 1'b0;
        wait_cyc(20);

        // R3: coarse step unit.
        scen = "R3";
        set_cfg(3, 1'b1, 0, 0, 0, 1'b1);
        wait_cyc(80);
        set_cfg(0, 1'b1, 0, 0, 0, 1'b1);
        wait_cyc(40);

        // R9: settings rewritten every cycle; exit and signal random.
        scen = "R9";
        for (int i = 0; i < 1500; i++) begin
            set_cfg(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            rssi_above = 1'($urandom_range(0, 1));
            rx_exit    = ($urandom_range(0, 5) == 0);
            wait_cyc(1);
        end

        // R1: reset again mid-operation.
        scen = "R1";
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule